// File: doc/BRIEF.md
# Programmable Multi-Bank Clock Skew Generator

The block derives four banks of two clock outputs from one fast timing clock. Every timing-clock cycle is one skew unit (tU). A three-level range select fixes the length of the undivided output period at 32, 16 or 8 ticks. The output is a square wave that is high for the first half of each period. This undivided, unshifted wave is the zero-skew reference.

Each bank has a two-digit three-level code. The code moves the bank's square wave earlier or later than the reference in whole tU steps. The step is one tU on banks 1 and 2 and two tU on banks 3 and 4. Two codes of banks 3 and 4 do not shift the wave. They select a divided copy of the reference instead, and on bank 4 one of them selects an inverted copy.

A global edge select inverts the reference so that all banks follow the opposite reference edge. A per-bank enable mask forces a bank low. New codes, a new range and a new edge select wait for a period boundary, so a change never cuts a pulse short.

Top module: `clk_skew_gen`

## Requirements
- R1: `range_sel` encodes 00 as L, 01 as M, 10 as H and 11 as M. The output period is 32 ticks for L, 16 ticks for M and 8 ticks for H. A zero-skew bank is high for the first half of the period. The value a bank takes for period tick p is registered on the clock edge that processes tick p. Tick 0 is processed on the first edge after reset is released.
- R2: Bank b takes its code from `bank_code[4b+3:4b]` (b counted from 0). Bits [3:2] hold the first digit and bits [1:0] the second, each coded 00=L, 01=M, 10=H and 11=M. On banks 1 and 2 the codes LL, LM, LH, ML, MM, MH, HL, HM and HH shift the wave by -4, -3, -2, -1, 0, +1, +2, +3 and +4 tU.
- R3: On banks 3 and 4 the codes LM, LH, ML, MM, MH, HL and HM shift the wave by -6, -4, -2, 0, +2, +4 and +6 tU.
- R4: Code LL on bank 3 or bank 4 gives the reference divided by two. A count of reference rising edges since reset drives the divided outputs. It advances on every tick where the reference rises, and tick 0 after reset counts as a rise when the edge select is 0. The divide-by-two output is bit 0 of this count, so it goes high at the first rise.
- R5: Code HH on bank 3 gives the reference divided by four, which is bit 1 of the R4 count. Code HH on bank 4 gives the inverse of the reference.
- R6: A shift of d tU gives at tick p the value that the reference has at tick (p - d) modulo the period. A negative d therefore leads the reference and a positive d lags it. The shift wraps around the period, including the 8-tick range.
- R7: The two outputs of a bank, `clk_out[2b]` and `clk_out[2b+1]`, always carry the same value.
- R8: A new bank code, range or edge select is sampled on the clock edge that processes the last tick of the current period. It takes effect from tick 0 of the next period. A change made at any other time has no effect until that boundary.
- R9: With `edge_sel` at 1, the reference is inverted: it is low for the first half of the period and rises at tick period/2. Shifted, inverted and divided outputs follow the inverted reference.
- R10: With `out_en[b]` at 0 on a clock edge, bank b's outputs are 0 after that edge. Enabling takes effect on the next edge, without waiting for a period boundary.
- R11: While `rst` is high, all outputs are 0, the period restarts at tick 0 and the divide count is cleared. The bank codes, range and edge select present during reset are the ones used afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock; one cycle is one tU |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Three-level range select (00 L, 01 M, 10 H, 11 M) |
| edge_sel | input | 1 | 1 inverts the zero-skew reference |
| bank_code | input | 16 | Two-digit code per bank, bank b at [4b+3:4b] |
| out_en | input | 4 | Per-bank output enable; 0 forces the bank low |
| clk_out | output | 8 | Bank outputs, bank b on bits [2b+1:2b] |

## Verification
Every output is one register away from the period counter. The value for period tick p therefore appears just after the edge that processes tick p. Tick 0 is processed on the first edge after reset. The bench samples the outputs on each falling clock edge and holds its own tick counter, which advances once per sample and wraps at the active period.

New codes, range and edge select are captured by the bench model on the sample that follows the last tick of a period and are applied at the next tick 0. This reproduces the one-period wait of R8 without reading the design. The enable mask acts on the very next edge, so the bench compares against the mask it drove before that edge and changes its inputs only after a sample.

// File: rtl/skew_pkg.sv
package skew_pkg;

  // What a bank does with its HH code when its step is doubled
  typedef enum logic [1:0] {HH_SHIFT, HH_DIV4, HH_INV} hh_kind_t;

  // Per-bank waveform source
  typedef enum logic [1:0] {SRC_SHIFT, SRC_DIV2, SRC_DIV4, SRC_INV} src_t;

  // Three-level digit to 0/1/2; the unused pattern reads as mid
  function automatic logic [1:0] level_of(input logic [1:0] d);
    case (d)
      2'b00:   return 2'd0;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // Two digits to an index 0..8 (first digit weighs three)
  function automatic logic [3:0] code_index(input logic [3:0] c);
    logic [3:0] hi;
    hi = {2'b00, level_of(c[3:2])};
    return (hi << 1) + hi + {2'b00, level_of(c[1:0])};
  endfunction

  function automatic bit wide_step_for(input int b);
    return b >= 2;
  endfunction

  function automatic hh_kind_t hh_kind_for(input int b);
    if (b == 2) return HH_DIV4;
    if (b == 3) return HH_INV;
    return HH_SHIFT;
  endfunction

endpackage

// File: rtl/skew_timebase.sv
module skew_timebase #(
  parameter int MF_LOW  = 32,
  parameter int MF_MID  = 16,
  parameter int MF_HIGH = 8,
  localparam int MFW    = $clog2(MF_LOW) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     range_sel,
  input  logic           edge_sel,
  output logic [MFW-1:0] cnt,
  output logic [MFW-1:0] mf,
  output logic           edge_act,
  output logic           bound,
  output logic [1:0]     div_nxt
);

  logic [MFW-1:0] mf_sel;
  logic [1:0]     div_r;
  logic           rise;

  always_comb begin
    case (range_sel)
      2'b00:   mf_sel = MFW'(MF_LOW);
      2'b10:   mf_sel = MFW'(MF_HIGH);
      default: mf_sel = MFW'(MF_MID);
    endcase
  end

  assign bound   = (cnt == mf - MFW'(1));
  assign rise    = edge_act ? (cnt == (mf >> 1)) : (cnt == '0);
  assign div_nxt = div_r + {1'b0, rise};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      mf       <= mf_sel;
      edge_act <= edge_sel;
      div_r    <= '0;
    end else begin
      div_r <= div_nxt;
      if (bound) begin
        cnt      <= '0;
        mf       <= mf_sel;
        edge_act <= edge_sel;
      end else begin
        cnt <= cnt + MFW'(1);
      end
    end
  end

endmodule

// File: rtl/skew_bank.sv
module skew_bank
  import skew_pkg::*;
#(
  parameter int       MFW  = 6,
  parameter int       OUTS = 2,
  parameter bit       WIDE = 1'b0,
  parameter hh_kind_t HH   = HH_SHIFT,
  localparam int      SW   = MFW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bound,
  input  logic [3:0]      code_in,
  input  logic            en,
  input  logic [MFW-1:0]  cnt,
  input  logic [MFW-1:0]  mf,
  input  logic            edge_act,
  input  logic [1:0]      div_nxt,
  output logic [3:0]      code_act,
  output logic [OUTS-1:0] q
);

  logic [3:0]           idx;
  logic signed [SW-1:0] sidx, off, s, cnt_s, mf_s;
  logic [MFW-1:0]       half;
  logic                 ref_lvl, shift_lvl, val;
  src_t                 src;

  assign idx  = code_index(code_act);
  assign sidx = $signed({{(SW-4){1'b0}}, idx}) - $signed(SW'(4));

  generate
    if (WIDE) begin : g_wide
      assign off = sidx <<< 1;
    end else begin : g_narrow
      assign off = sidx;
    end
  endgenerate

  always_comb begin
    src = SRC_SHIFT;
    if (WIDE && idx == 4'd0) begin
      src = SRC_DIV2;
    end else if (WIDE && idx == 4'd8) begin
      case (HH)
        HH_DIV4: src = SRC_DIV4;
        HH_INV:  src = SRC_INV;
        default: src = SRC_SHIFT;
      endcase
    end
  end

  assign cnt_s = $signed({2'b00, cnt});
  assign mf_s  = $signed({2'b00, mf});
  assign half  = mf >> 1;

  // Position inside the period after the shift, wrapped once
  always_comb begin
    s = cnt_s - off;
    if (s < 0)
      s = s + mf_s;
    else if (s >= mf_s)
      s = s - mf_s;
  end

  assign ref_lvl   = (cnt < half) ^ edge_act;
  assign shift_lvl = (s[MFW-1:0] < half) ^ edge_act;

  always_comb begin
    case (src)
      SRC_DIV2: val = div_nxt[0];
      SRC_DIV4: val = div_nxt[1];
      SRC_INV:  val = ~ref_lvl;
      default:  val = shift_lvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || bound) code_act <= code_in;
  end

  // One flop per output pin so each pin has its own driver
  generate
    for (genvar o = 0; o < OUTS; o++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst) q[o] <= 1'b0;
        else     q[o] <= en & val;
      end
    end
  endgenerate

endmodule

// File: rtl/clk_skew_gen.sv
module clk_skew_gen
  import skew_pkg::*;
#(
  parameter int  NUM_BANKS = 4,
  parameter int  OUTS      = 2,
  parameter int  MF_LOW    = 32,
  parameter int  MF_MID    = 16,
  parameter int  MF_HIGH   = 8,
  localparam int MFW       = $clog2(MF_LOW) + 1,
  localparam int CODE_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                range_sel,
  input  logic                      edge_sel,
  input  logic [NUM_BANKS*CODE_W-1:0] bank_code,
  input  logic [NUM_BANKS-1:0]      out_en,
  output logic [NUM_BANKS*OUTS-1:0] clk_out
);

  logic [MFW-1:0]              cnt_w, mf_w;
  logic                        edge_w, bound_w;
  logic [1:0]                  div_w;
  logic [NUM_BANKS*CODE_W-1:0] code_act_w;

  skew_timebase #(
    .MF_LOW (MF_LOW),
    .MF_MID (MF_MID),
    .MF_HIGH(MF_HIGH)
  ) u_timebase (
    .clk      (clk),
    .rst      (rst),
    .range_sel(range_sel),
    .edge_sel (edge_sel),
    .cnt      (cnt_w),
    .mf       (mf_w),
    .edge_act (edge_w),
    .bound    (bound_w),
    .div_nxt  (div_w)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      skew_bank #(
        .MFW (MFW),
        .OUTS(OUTS),
        .WIDE(wide_step_for(b)),
        .HH  (hh_kind_for(b))
      ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .bound   (bound_w),
        .code_in (bank_code[b*CODE_W +: CODE_W]),
        .en      (out_en[b]),
        .cnt     (cnt_w),
        .mf      (mf_w),
        .edge_act(edge_w),
        .div_nxt (div_w),
        .code_act(code_act_w[b*CODE_W +: CODE_W]),
        .q       (clk_out[b*OUTS +: OUTS])
      );
    end
  endgenerate

endmodule

// File: rtl/skew_gen_checker.sv
module skew_gen_checker #(
  parameter int NUM_BANKS = 4,
  parameter int OUTS      = 2,
  parameter int MFW       = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic [MFW-1:0]            cnt,
  input logic [MFW-1:0]            mf,
  input logic                      bound,
  input logic [NUM_BANKS*4-1:0]    code_act,
  input logic [NUM_BANKS-1:0]      out_en,
  input logic [NUM_BANKS*OUTS-1:0] clk_out
);

  logic [NUM_BANKS*OUTS-1:0] en_mask;

  always_comb begin
    for (int i = 0; i < NUM_BANKS * OUTS; i++) en_mask[i] = out_en[i / OUTS];
  end

  // R1: the tick counter never reaches the active period length
  p_cnt_below_mf_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < mf);

  // R8: active codes move only after a period boundary
  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(bound) && !$past(rst)) |-> $stable(code_act));

  // R8: the active period length moves only after a period boundary
  p_range_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(bound) && !$past(rst)) |-> $stable(mf));

  // R10: a bank disabled on an edge is low after it
  p_disabled_low_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((clk_out & ~$past(en_mask)) == '0));

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pair
      // R7: both pins of a bank agree
      p_pair_same_r7: assert property (@(posedge clk) disable iff (rst)
        clk_out[b*OUTS +: OUTS] == {OUTS{clk_out[b*OUTS]}});
    end
  endgenerate

endmodule

bind clk_skew_gen skew_gen_checker #(
  .NUM_BANKS(NUM_BANKS),
  .OUTS     (OUTS),
  .MFW      (MFW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt     (cnt_w),
  .mf      (mf_w),
  .bound   (bound_w),
  .code_act(code_act_w),
  .out_en  (out_en),
  .clk_out (clk_out)
);

// File: tb/test_clk_skew_gen.sv
module test_clk_skew_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  range_sel = 2'b01;
  logic        edge_sel = 1'b0;
  logic [15:0] bank_code = 16'h5555;
  logic [3:0]  out_en = 4'hF;
  logic [7:0]  clk_out;

  always #5 clk = ~clk;

  clk_skew_gen i_clk_skew_gen (
    .clk      (clk),
    .rst      (rst),
    .range_sel(range_sel),
    .edge_sel (edge_sel),
    .bank_code(bank_code),
    .out_en   (out_en),
    .clk_out  (clk_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model state
  int          ph, rises, a_mf, p_mf;
  logic        a_edge, p_edge;
  logic [15:0] a_code, p_code;

  localparam logic [3:0] LL = 4'b0000, LM = 4'b0001, LH = 4'b0010,
                         ML = 4'b0100, MM = 4'b0101, MH = 4'b0110,
                         HL = 4'b1000, HM = 4'b1001, HH = 4'b1010;

  function automatic int mf_of(input logic [1:0] r);
    if (r == 2'b00) return 32;
    if (r == 2'b10) return 8;
    return 16;
  endfunction

  function automatic int lv(input logic [1:0] d);
    if (d == 2'b00) return 0;
    if (d == 2'b10) return 2;
    return 1;
  endfunction

  function automatic logic exp_bank(input int b, input logic [3:0] c, input int mf,
                                    input logic e, input int p, input int r);
    int   idx, off, s;
    logic refl;
    idx  = 3 * lv(c[3:2]) + lv(c[1:0]);
    refl = (p < mf / 2) ^ e;
    if (b >= 2 && idx == 0) return logic'(r % 2);
    if (b == 2 && idx == 8) return logic'((r / 2) % 2);
    if (b == 3 && idx == 8) return ~refl;
    off = (b >= 2) ? 2 * (idx - 4) : idx - 4;
    s   = ((p - off) % mf + mf) % mf;
    return (s < mf / 2) ^ e;
  endfunction

  // Both pins are compared against one expected value (R7)
  task automatic check(input string req, input int b, input logic [1:0] got,
                       input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s bank %0d tick %0d: got %b expected %b", req, b + 1, ph, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int b = 0; b < 4; b++) check("R11", b, clk_out[2*b +: 2], 2'b00);
    rst    = 1'b0;
    ph     = 0;
    rises  = 0;
    a_mf   = mf_of(range_sel);
    p_mf   = a_mf;
    a_edge = edge_sel;
    p_edge = edge_sel;
    a_code = bank_code;
    p_code = bank_code;
  endtask

  task automatic step(input string req);
    logic e;
    @(negedge clk);
    if (ph == 0) begin
      a_mf   = p_mf;
      a_edge = p_edge;
      a_code = p_code;
    end
    if (a_edge ? (ph == a_mf / 2) : (ph == 0)) rises++;
    for (int b = 0; b < 4; b++) begin
      e = out_en[b] ? exp_bank(b, a_code[4*b +: 4], a_mf, a_edge, ph, rises) : 1'b0;
      check(req, b, clk_out[2*b +: 2], {e, e});
    end
    if (ph == a_mf - 1) begin
      p_mf   = mf_of(range_sel);
      p_edge = edge_sel;
      p_code = bank_code;
    end
    ph = (ph == a_mf - 1) ? 0 : ph + 1;
  endtask

  task automatic run(input string req, input int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic setup(input logic [1:0] r, input logic e, input logic [3:0] c1,
                       input logic [3:0] c2, input logic [3:0] c3, input logic [3:0] c4);
    range_sel = r;
    edge_sel  = e;
    bank_code = {c4, c3, c2, c1};
    out_en    = 4'hF;
    do_reset();
  endtask

  task automatic t_basic_offsets();   // R1 R2 R6
    setup(2'b01, 1'b0, LL, HH, MM, MM);
    run("R1 R2 R6", 48);
    setup(2'b00, 1'b0, LM, LH, MH, ML);
    run("R1 R2 R3", 70);
  endtask

  task automatic t_wide_wrap();       // R3 R6
    setup(2'b10, 1'b0, HL, HM, LM, HM);
    run("R3 R6", 32);
    setup(2'b01, 1'b0, ML, MH, LH, HL);
    run("R2 R3", 34);
  endtask

  task automatic t_divide_invert();   // R4 R5
    setup(2'b10, 1'b0, MM, MM, LL, LL);
    run("R4", 40);
    setup(2'b10, 1'b0, MM, MM, HH, HH);
    run("R5", 40);
  endtask

  task automatic t_edge_select();     // R9
    setup(2'b01, 1'b1, MM, MH, LL, HH);
    run("R9", 50);
    setup(2'b10, 1'b1, LH, HL, HH, LM);
    run("R9", 30);
  endtask

  task automatic t_enable_mask();     // R10
    setup(2'b10, 1'b0, MM, HM, LL, HH);
    run("R10", 6);
    out_en = 4'b0101;
    run("R10", 11);
    out_en = 4'b1010;
    run("R10", 9);
    out_en = 4'b1111;
    run("R10", 10);
  endtask

  task automatic t_mid_period_change(); // R8
    setup(2'b01, 1'b0, MM, MM, MM, MM);
    run("R8", 5);
    bank_code = {HM, LM, HH, LL};
    range_sel = 2'b10;
    run("R8", 30);
    edge_sel  = 1'b1;
    bank_code = {HH, HH, MH, LH};
    run("R8", 3);
    range_sel = 2'b00;
    run("R8", 70);
  endtask

  task automatic t_spare_encoding();  // R1 R2: 11 reads as mid
    setup(2'b11, 1'b0, 4'b1111, 4'b0011, 4'b1100, 4'b1111);
    run("R1 R2", 40);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_basic_offsets();
    t_wide_wrap();
    t_divide_invert();
    t_edge_select();
    t_enable_mask();
    t_mid_period_change();
    t_spare_encoding();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got no finish expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule